// File: doc/BRIEF.md
# Power-Gating Sleep/Wake Sequencer

This always-on controller manages one switchable power domain. On a sleep request it takes the domain down in a fixed order. It stops the domain clock, clamps the domain outputs, pulses the retention save strobe, asserts the domain reset and then removes power. On a wake request it runs the mirror-image order. It applies power, waits for the switch network to report power good, pulses the retention restore strobe, releases reset, restarts the clock and finally removes the clamps.

Every timed step is held for a programmable number of clock cycles, so the same logic can serve switch networks and retention cells of different speeds. A one-cycle acknowledge marks each accepted request. A two-bit status tells the rest of the chip whether the domain is off, on or between the two. A request that arrives while a sequence is running is discarded.

Top module: `pwr_gate_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, the outputs are: clock enable 0, isolate_n 0, save 0, reset_n 0, power_on_n 1, restore 0. In the same cycles status reads OFF (2'b00) and the acknowledge is 0.
- R2: A sleep request taken in the ON state steps through five control vectors, written as {clk_en, iso_n, save, rst_n, pwr_on_n, restore}: 010100, 000100, 001100, 000000, 000010. The block then enters OFF, whose vector is 000010.
- R3: A wake request taken in the OFF state steps through these vectors: 000000 (power on), 000000 (acknowledge wait), 000001, 000100, 100100, 110100. The block then enters ON, whose vector is 110100.
- R4: Each step other than the acknowledge wait lasts exactly max(step_cycles, 1) cycles. A step_cycles value of 0 therefore behaves as 1.
- R5: The acknowledge-wait step lasts until pwr_ack is sampled high and is left on the following edge. If pwr_ack is already high, the step lasts one cycle. Restore never rises unless pwr_ack was high in the cycle before.
- R6: A request of either kind is ignored while a sequence runs. A sleep request in OFF and a wake request in ON are also ignored. Ignored requests leave the control vectors, the status and the step timing unchanged.
- R7: Status is 2'b01 in ON and 2'b10 during any sequence, and never 2'b11.
- R8: req_ack is high for exactly one cycle, in the first cycle of an accepted sequence, and is low at all other times.
- R9: Save is high only while power is on, reset is released, isolation is asserted and the clock is stopped. Restore is high only while power is on, reset is asserted, isolation is asserted and the clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep_req | input | 1 | Request to power the domain down |
| wake_req | input | 1 | Request to power the domain up |
| pwr_ack | input | 1 | Power-good acknowledge from the switch network |
| step_cycles | input | CNT_W | Hold length of each timed step, in cycles |
| clk_en | output | 1 | Domain clock enable |
| iso_n | output | 1 | Output clamp, active low |
| save | output | 1 | Retention save strobe |
| rst_n | output | 1 | Domain reset, active low |
| pwr_on_n | output | 1 | Power switch control, active low |
| restore | output | 1 | Retention restore strobe |
| status | output | 2 | 00 OFF, 01 ON, 10 transition |
| req_ack | output | 1 | One-cycle pulse when a request is accepted |

## Verification
The bench uses the default CNT_W of 8. Most sequences draw step lengths from 0 to 4, so the zero-as-one rule and single-cycle steps are exercised often while each run stays short. One directed sleep sequence uses step_cycles of 255, which reaches the largest hold the counter can express. The acknowledge delay is drawn at random, including the case where the acknowledge is already present, and opposing requests are held active during sequences to confirm they are discarded.

// File: rtl/pwr_gate_pkg.sv
package pwr_gate_pkg;

  typedef enum logic [3:0] {
    PG_OFF, PG_ON,
    SL_CLK, SL_ISO, SL_SAVE, SL_RST, SL_PWR,
    WK_PWR, WK_ACK, WK_RESTORE, WK_RST, WK_CLK, WK_ISO
  } pg_state_e;

  typedef struct packed {
    logic clk_en;
    logic iso_n;
    logic save;
    logic rst_n;
    logic pwr_on_n;
    logic restore;
  } pg_ctrl_t;

  localparam logic [1:0] ST_OFF   = 2'b00;
  localparam logic [1:0] ST_ON    = 2'b01;
  localparam logic [1:0] ST_TRANS = 2'b10;

  // Control vector presented while the sequencer sits in a given state.
  function automatic pg_ctrl_t ctrl_of(pg_state_e s);
    pg_ctrl_t c;
    case (s)
      PG_ON:      c = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
      SL_CLK:     c = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
      SL_ISO:     c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
      SL_SAVE:    c = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
      SL_RST:     c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      SL_PWR:     c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
      WK_PWR:     c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      WK_ACK:     c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
      WK_RESTORE: c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      WK_RST:     c = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
      WK_CLK:     c = '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0};
      WK_ISO:     c = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0};
      default:    c = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pwr_gate_timer.sv
module pwr_gate_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] len,
  output logic             done
);
  logic [CNT_W-1:0] cnt_q;

  // A step of length len occupies len cycles; zero is treated as one.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= (len == '0) ? '0 : len - 1'b1;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/pwr_gate_fsm.sv
module pwr_gate_fsm
  import pwr_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      sleep_req,
  input  logic      wake_req,
  input  logic      pwr_ack,
  input  logic      step_done,
  output pg_state_e state_q,
  output pg_state_e state_d
);
  always_comb begin
    state_d = state_q;
    case (state_q)
      PG_ON:      if (sleep_req) state_d = SL_CLK;
      PG_OFF:     if (wake_req)  state_d = WK_PWR;
      SL_CLK:     if (step_done) state_d = SL_ISO;
      SL_ISO:     if (step_done) state_d = SL_SAVE;
      SL_SAVE:    if (step_done) state_d = SL_RST;
      SL_RST:     if (step_done) state_d = SL_PWR;
      SL_PWR:     if (step_done) state_d = PG_OFF;
      WK_PWR:     if (step_done) state_d = WK_ACK;
      WK_ACK:     if (pwr_ack)   state_d = WK_RESTORE;
      WK_RESTORE: if (step_done) state_d = WK_RST;
      WK_RST:     if (step_done) state_d = WK_CLK;
      WK_CLK:     if (step_done) state_d = WK_ISO;
      WK_ISO:     if (step_done) state_d = PG_ON;
      default:                   state_d = PG_OFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= PG_OFF;
    else     state_q <= state_d;
  end
endmodule

// File: rtl/pwr_gate_outreg.sv
module pwr_gate_outreg
  import pwr_gate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  pg_state_e state_q,
  input  pg_state_e state_d,
  output pg_ctrl_t  ctrl,
  output logic [1:0] status,
  output logic      req_ack
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl    <= ctrl_of(PG_OFF);
      status  <= ST_OFF;
      req_ack <= 1'b0;
    end else begin
      ctrl    <= ctrl_of(state_d);
      status  <= (state_d == PG_OFF) ? ST_OFF :
                 (state_d == PG_ON)  ? ST_ON  : ST_TRANS;
      req_ack <= ((state_q == PG_ON)  && (state_d == SL_CLK)) ||
                 ((state_q == PG_OFF) && (state_d == WK_PWR));
    end
  end
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq
  import pwr_gate_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sleep_req,
  input  logic             wake_req,
  input  logic             pwr_ack,
  input  logic [CNT_W-1:0] step_cycles,
  output logic             clk_en,
  output logic             iso_n,
  output logic             save,
  output logic             rst_n,
  output logic             pwr_on_n,
  output logic             restore,
  output logic [1:0]       status,
  output logic             req_ack
);
  pg_state_e state_q, state_d;
  logic      step_done;
  pg_ctrl_t  ctrl;

  pwr_gate_timer #(.CNT_W(CNT_W)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .load (state_d != state_q),
    .len  (step_cycles),
    .done (step_done)
  );

  pwr_gate_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .sleep_req (sleep_req),
    .wake_req  (wake_req),
    .pwr_ack   (pwr_ack),
    .step_done (step_done),
    .state_q   (state_q),
    .state_d   (state_d)
  );

  pwr_gate_outreg u_out (
    .clk     (clk),
    .rst     (rst),
    .state_q (state_q),
    .state_d (state_d),
    .ctrl    (ctrl),
    .status  (status),
    .req_ack (req_ack)
  );

  assign clk_en   = ctrl.clk_en;
  assign iso_n    = ctrl.iso_n;
  assign save     = ctrl.save;
  assign rst_n    = ctrl.rst_n;
  assign pwr_on_n = ctrl.pwr_on_n;
  assign restore  = ctrl.restore;
endmodule

// File: rtl/pwr_gate_seq_chk.sv
module pwr_gate_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       pwr_ack,
  input logic       clk_en,
  input logic       iso_n,
  input logic       save,
  input logic       rst_n,
  input logic       pwr_on_n,
  input logic       restore,
  input logic [1:0] status,
  input logic       req_ack
);
  a_r9_save_safe: assert property (@(posedge clk) disable iff (rst)
    save |-> (!pwr_on_n && rst_n && !iso_n && !clk_en));

  a_r9_restore_safe: assert property (@(posedge clk) disable iff (rst)
    restore |-> (!pwr_on_n && !rst_n && !iso_n && !clk_en));

  a_r7_no_bad_code: assert property (@(posedge clk) disable iff (rst)
    status != 2'b11);

  a_r7_on_vector: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b01) |-> (clk_en && iso_n && rst_n && !pwr_on_n));

  a_r7_off_vector: assert property (@(posedge clk) disable iff (rst)
    (status == 2'b00) |-> (pwr_on_n && !clk_en && !iso_n && !rst_n));

  a_r8_ack_single: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack);

  a_r5_restore_after_ack: assert property (@(posedge clk) disable iff (rst)
    $rose(restore) |-> $past(pwr_ack));

  a_r2_power_off_order: assert property (@(posedge clk) disable iff (rst)
    $rose(pwr_on_n) |-> (!rst_n && !iso_n && !clk_en));

  a_r3_clamp_release_last: assert property (@(posedge clk) disable iff (rst)
    $rose(iso_n) |-> (clk_en && rst_n && !pwr_on_n));
endmodule

bind pwr_gate_seq pwr_gate_seq_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .pwr_ack  (pwr_ack),
  .clk_en   (clk_en),
  .iso_n    (iso_n),
  .save     (save),
  .rst_n    (rst_n),
  .pwr_on_n (pwr_on_n),
  .restore  (restore),
  .status   (status),
  .req_ack  (req_ack)
);

// File: tb/pwr_gate_seq_test.sv
module pwr_gate_seq_test;
  localparam int CW = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sleep_req = 1'b0;
  logic wake_req = 1'b0;
  logic pwr_ack = 1'b0;
  logic [CW-1:0] step_cycles = 8'd1;
  logic clk_en, iso_n, save, rst_n, pwr_on_n, restore, req_ack;
  logic [1:0] status;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  pwr_gate_seq #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .sleep_req(sleep_req), .wake_req(wake_req),
    .pwr_ack(pwr_ack), .step_cycles(step_cycles), .clk_en(clk_en),
    .iso_n(iso_n), .save(save), .rst_n(rst_n), .pwr_on_n(pwr_on_n),
    .restore(restore), .status(status), .req_ack(req_ack)
  );

  always #4 clk = ~clk;

  localparam logic [1:0] S_OFF = 2'b00, S_ON = 2'b01, S_TR = 2'b10;
  localparam logic [5:0] V_ON = 6'b110100, V_OFF = 6'b000010;

  function automatic logic [5:0] sleep_vec(int i);
    case (i)
      0: return 6'b010100;
      1: return 6'b000100;
      2: return 6'b001100;
      3: return 6'b000000;
      default: return 6'b000010;
    endcase
  endfunction

  function automatic logic [5:0] wake_vec(int i);
    case (i)
      0: return 6'b000001;
      1: return 6'b000100;
      2: return 6'b100100;
      default: return 6'b110100;
    endcase
  endfunction

  function automatic int eff(int n);
    return (n == 0) ? 1 : n;
  endfunction

  function automatic logic [8:0] observed();
    return {status, req_ack, clk_en, iso_n, save, rst_n, pwr_on_n, restore};
  endfunction

  task automatic chk(string tag, logic [8:0] act, logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, act, exp);
    end
  endtask

  // Checks one step for n cycles starting at its first cycle, ends aligned
  // to the first cycle of the following step.
  task automatic expect_step(string tag, logic [5:0] v, logic [1:0] st,
                             int n, bit ack_first);
    for (int i = 0; i < n; i++) begin
      chk(tag, observed(), {st, (ack_first && i == 0), v});
      @(negedge clk);
    end
  endtask

  task automatic run_sleep(int n, bit noise);
    step_cycles = n[CW-1:0];
    pwr_ack = 1'b0;
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    wake_req = noise;
    for (int s = 0; s < 5; s++) begin
      if (s == 4) wake_req = 1'b0;
      expect_step((s == 2) ? "R2 R4 R6 R8 R9 sleep save step" :
                             "R2 R4 R6 R7 R8 sleep step",
                  sleep_vec(s), S_TR, eff(n), s == 0);
    end
    sleep_req = noise;
    expect_step("R1 R6 R7 off held", V_OFF, S_OFF, 3, 1'b0);
    sleep_req = 1'b0;
    @(negedge clk);
    chk("R6 off after ignored sleep", observed(), {S_OFF, 1'b0, V_OFF});
  endtask

  task automatic run_wake(int n, int k, bit noise);
    step_cycles = n[CW-1:0];
    pwr_ack = (k == 0);
    wake_req = 1'b1;
    @(negedge clk);
    wake_req = 1'b0;
    sleep_req = noise;
    expect_step("R3 R4 R8 power-on step", 6'b000000, S_TR, eff(n), 1'b1);
    if (k == 0) begin
      expect_step("R5 ack already present", 6'b000000, S_TR, 1, 1'b0);
    end else begin
      expect_step("R5 ack wait", 6'b000000, S_TR, k, 1'b0);
      pwr_ack = 1'b1;
      expect_step("R5 ack seen", 6'b000000, S_TR, 1, 1'b0);
    end
    for (int s = 0; s < 4; s++) begin
      if (s == 3) sleep_req = 1'b0;
      expect_step((s == 0) ? "R3 R4 R6 R9 restore step" : "R3 R4 R6 R7 wake step",
                  wake_vec(s), S_TR, eff(n), 1'b0);
    end
    wake_req = noise;
    expect_step("R6 R7 on held", V_ON, S_ON, 3, 1'b0);
    wake_req = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    chk("R1 during reset", observed(), {S_OFF, 1'b0, V_OFF});
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", observed(), {S_OFF, 1'b0, V_OFF});
    wake_req = 1'b0;
    // directed: minimum lengths, immediate ack
    run_wake(0, 0, 1'b0);
    run_sleep(1, 1'b1);
    run_wake(2, 3, 1'b1);
    run_sleep(255, 1'b0);
    for (int it = 0; it < 12; it++) begin
      run_wake($urandom % 5, $urandom % 4, 1'($urandom % 2));
      run_sleep($urandom % 5, 1'($urandom % 2));
    end
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog R1 actual hung expected done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule